// File: doc/BRIEF.md
# Interrupt Arbiter and Acknowledge Sequencer

This block sits in the control path of a small processor core. At each instruction boundary it decides whether an interrupt is taken. It watches two request sources:

- a non-maskable line that reacts to rising edges and may arrive asynchronously;
- a maskable line that is level sensitive and gated by the interrupt-enable flag.

The non-maskable source always wins. It uses the fixed type 2, so its table address is 0x008.

For a maskable request, the block runs two back-to-back acknowledge bus cycles, each stepped through states T1 to T4 by a bus state tick. It reads the type byte only in the second cycle. It then presents the vector-table address, which is the type multiplied by four. For every response it also produces:

- a one-cycle pulse that clears the enable flag;
- a copy of the flag as it was before the response, for the stack;
- a lock window;
- a hold inhibit that keeps other bus masters off the bus during the acknowledge pair.

The sequencer states are:

- `SQ_IDLE`: waiting for a boundary.
- `SQ_C1_T1` to `SQ_C1_T4`: first acknowledge cycle.
- `SQ_C2_T1` to `SQ_C2_T4`: second acknowledge cycle.
- `SQ_VEC`: vector presentation for one cycle.

The transitions are:

- take-NMI: `SQ_IDLE` to `SQ_VEC` on a boundary while the NMI latch is pending.
- take-INTR: `SQ_IDLE` to `SQ_C1_T1` on a boundary with no NMI pending, the sampled level high and the enable flag set.
- bus-step: each `SQ_Cx_Ty` moves to the next state on a tick. `SQ_C1_T4` moves to `SQ_C2_T1`, and `SQ_C2_T4` moves to `SQ_VEC`.
- finish: `SQ_VEC` returns to `SQ_IDLE` unconditionally.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `take_o`, `inta_o`, `lock_o`, `hold_blk_o` and `ien_clr_o` are low, and no NMI or maskable request is pending.
- R2: A low-to-high transition on `nmi_i` is synchronised through two flops, latched, and taken at the next boundary whether the enable flag is set or clear. The response state follows the boundary edge. In that cycle `take_o` is high and `vec_o` equals 0x008 (type 2 times 4).
- R3: A new rising edge on `nmi_i` that arrives after the NMI response has begun is latched and gives a second response at a later boundary. A level left high with no new edge gives no further response.
- R4: When an NMI is pending and a maskable request is also valid at the same boundary, the NMI is taken. The maskable request remains eligible at a later boundary.
- R5: `intr_i` is registered on every rising clock edge. A boundary starts a maskable response only if that register is high, meaning `intr_i` was high on the edge before the boundary edge, and `ien_i` is high. Otherwise the boundary is ignored.
- R6: A maskable response steps through `SQ_C1_T1`..`SQ_C1_T4` and then `SQ_C2_T1`..`SQ_C2_T4`, advancing only on clock edges where `bus_tick_i` is high. `inta_o` is high in T2 and T3 of both cycles. `take_o` pulses high for the one cycle after `SQ_C2_T4`.
- R7: `lock_o` is high from T2 of the first acknowledge cycle up to, but not including, T2 of the second. `hold_blk_o` is high in every state of both acknowledge cycles.
- R8: `ien_clr_o` pulses high for exactly one cycle, the cycle after the boundary that starts any response. `ien_save_o` holds the value `ien_i` had at that boundary.
- R9: The type byte on `ack_data_i` is captured only on the tick that ends T3 of the second cycle. `vec_o` is then `{type, 2'b00}`, for example 0xFF gives 0x3FC and 0x00 gives 0x000.
- R10: `boundary_i` is ignored while a response is in progress.
- R11: A maskable request held high is answered again at each later boundary where `ien_i` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_i | input | 1 | Non-maskable request, asynchronous, rising-edge sensitive |
| intr_i | input | 1 | Maskable request, level sensitive |
| ien_i | input | 1 | Interrupt-enable flag from the core |
| boundary_i | input | 1 | Instruction boundary strobe |
| bus_tick_i | input | 1 | Bus state advance tick |
| ack_data_i | input | 8 | Type byte driven during acknowledge |
| take_o | output | 1 | Interrupt taken, vector valid |
| vec_o | output | 10 | Vector-table byte address |
| ien_clr_o | output | 1 | Clear-enable pulse |
| ien_save_o | output | 1 | Enable flag value before the response |
| inta_o | output | 1 | Acknowledge strobe |
| lock_o | output | 1 | Bus lock |
| hold_blk_o | output | 1 | Hold-grant inhibit |

## Verification
The bench builds the block with its defaults: an 8-bit type, NMI type 2 and a two-stage synchroniser. This makes the extreme type bytes 0x00 and 0xFF reachable, which cover both ends of the 0x000–0x3FF table. The tick input is held low in the middle of an acknowledge cycle to show that the sequencer stalls and that lock and the strobe persist while stalled. With the minimum two-flop synchroniser, the NMI edge reaches the pending latch three edges after the pin rises. The re-arm and collision timing is exercised against that latency.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_C1_T1, SQ_C1_T2, SQ_C1_T3, SQ_C1_T4,
        SQ_C2_T1, SQ_C2_T2, SQ_C2_T3, SQ_C2_T4,
        SQ_VEC
    } sq_state_t;
endpackage

// File: rtl/irq_nmi_catch.sv
module irq_nmi_catch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_async,
    input  logic clear_i,
    output logic pend_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;
    logic                   prev_q;
    logic                   rise;

    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= nmi_async;
    end

    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
        end
    end

    assign rise = chain[LAST] & ~prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_o <= 1'b0;
        end else begin
            prev_q <= chain[LAST];
            // a fresh edge wins over the clear, so service can re-arm
            pend_o <= rise | (pend_o & ~clear_i);
        end
    end

    // R3
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> pend_o);
    // R3
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !rise) |=> !pend_o);
endmodule

// File: rtl/irq_level_sample.sv
module irq_level_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic lvl_q_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q_o <= 1'b0;
        else        lvl_q_o <= lvl_i;
    end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_pkg::*;
#(
    parameter int TYPE_W   = 8,
    parameter int NMI_TYPE = 2,
    localparam int VEC_W   = TYPE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              nmi_pend_i,
    input  logic              intr_lvl_i,
    input  logic              ien_i,
    input  logic              tick_i,
    input  logic [TYPE_W-1:0] ack_data_i,
    output logic              nmi_take_o,
    output logic              take_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              ien_clr_o,
    output logic              ien_save_o,
    output logic              inta_o,
    output logic              lock_o,
    output logic              hold_blk_o
);
    localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NMI_TYPE * 4);

    sq_state_t state, nxt;
    logic      take_int;
    logic      src_nmi_q;
    logic      clr_q;

    assign nmi_take_o = (state == SQ_IDLE) && boundary_i && nmi_pend_i;
    assign take_int   = (state == SQ_IDLE) && boundary_i && !nmi_pend_i
                        && intr_lvl_i && ien_i;

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE: begin
                if (nmi_take_o)    nxt = SQ_VEC;
                else if (take_int) nxt = SQ_C1_T1;
            end
            SQ_C1_T1: if (tick_i) nxt = SQ_C1_T2;
            SQ_C1_T2: if (tick_i) nxt = SQ_C1_T3;
            SQ_C1_T3: if (tick_i) nxt = SQ_C1_T4;
            SQ_C1_T4: if (tick_i) nxt = SQ_C2_T1;
            SQ_C2_T1: if (tick_i) nxt = SQ_C2_T2;
            SQ_C2_T2: if (tick_i) nxt = SQ_C2_T3;
            SQ_C2_T3: if (tick_i) nxt = SQ_C2_T4;
            SQ_C2_T4: if (tick_i) nxt = SQ_VEC;
            SQ_VEC:               nxt = SQ_IDLE;
            default:              nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            vec_o      <= '0;
            src_nmi_q  <= 1'b0;
            clr_q      <= 1'b0;
            ien_save_o <= 1'b0;
        end else begin
            state <= nxt;
            clr_q <= nmi_take_o | take_int;
            if (nmi_take_o | take_int) ien_save_o <= ien_i;
            if (nmi_take_o) begin
                vec_o     <= NMI_VEC;
                src_nmi_q <= 1'b1;
            end else if (take_int) begin
                src_nmi_q <= 1'b0;
            end
            if (state == SQ_C2_T3 && tick_i) vec_o <= {ack_data_i, 2'b00};
        end
    end

    always_comb begin
        take_o     = 1'b0;
        inta_o     = 1'b0;
        lock_o     = 1'b0;
        hold_blk_o = 1'b0;
        unique case (state)
            SQ_IDLE: ;
            SQ_C1_T1: hold_blk_o = 1'b1;
            SQ_C1_T2, SQ_C1_T3: begin
                hold_blk_o = 1'b1; lock_o = 1'b1; inta_o = 1'b1;
            end
            SQ_C1_T4, SQ_C2_T1: begin
                hold_blk_o = 1'b1; lock_o = 1'b1;
            end
            SQ_C2_T2, SQ_C2_T3: begin
                hold_blk_o = 1'b1; inta_o = 1'b1;
            end
            SQ_C2_T4: hold_blk_o = 1'b1;
            SQ_VEC:   take_o = 1'b1;
            default: ;
        endcase
    end

    assign ien_clr_o = clr_q;

    // R7
    lock_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> hold_blk_o);
    // R7
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> state == SQ_C2_T2);
    // R6
    inta_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inta_o |-> hold_blk_o);
    // R6
    take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);
    // R2
    nmi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && src_nmi_q) |-> vec_o == NMI_VEC);
    // R8
    clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ien_clr_o |=> !ien_clr_o);
    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_IDLE && state != SQ_VEC && !tick_i) |=> $stable(state));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int TYPE_W      = 8,
    parameter int NMI_TYPE    = 2,
    parameter int SYNC_STAGES = 2,
    localparam int VEC_W      = TYPE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_i,
    input  logic              intr_i,
    input  logic              ien_i,
    input  logic              boundary_i,
    input  logic              bus_tick_i,
    input  logic [TYPE_W-1:0] ack_data_i,
    output logic              take_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              ien_clr_o,
    output logic              ien_save_o,
    output logic              inta_o,
    output logic              lock_o,
    output logic              hold_blk_o
);
    logic nmi_pend, nmi_take, intr_lvl;

    irq_nmi_catch #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
        .clk(clk), .rst_n(rst_n), .nmi_async(nmi_i),
        .clear_i(nmi_take), .pend_o(nmi_pend)
    );

    irq_level_sample u_lvl (
        .clk(clk), .rst_n(rst_n), .lvl_i(intr_i), .lvl_q_o(intr_lvl)
    );

    irq_ack_seq #(.TYPE_W(TYPE_W), .NMI_TYPE(NMI_TYPE)) u_seq (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i),
        .nmi_pend_i(nmi_pend), .intr_lvl_i(intr_lvl), .ien_i(ien_i),
        .tick_i(bus_tick_i), .ack_data_i(ack_data_i),
        .nmi_take_o(nmi_take), .take_o(take_o), .vec_o(vec_o),
        .ien_clr_o(ien_clr_o), .ien_save_o(ien_save_o),
        .inta_o(inta_o), .lock_o(lock_o), .hold_blk_o(hold_blk_o)
    );
endmodule

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_i = 1'b0, intr_i = 1'b0, ien_i = 1'b0;
    logic       boundary_i = 1'b0, bus_tick_i = 1'b1;
    logic [7:0] ack_data_i = 8'h00;
    logic       take_o, ien_clr_o, ien_save_o, inta_o, lock_o, hold_blk_o;
    logic [9:0] vec_o;

    int total = 0;
    int bad = 0;
    int takes = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_arbiter dut (
        .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .intr_i(intr_i),
        .ien_i(ien_i), .boundary_i(boundary_i), .bus_tick_i(bus_tick_i),
        .ack_data_i(ack_data_i), .take_o(take_o), .vec_o(vec_o),
        .ien_clr_o(ien_clr_o), .ien_save_o(ien_save_o), .inta_o(inta_o),
        .lock_o(lock_o), .hold_blk_o(hold_blk_o)
    );

    always @(negedge clk) if (rst_n && take_o) takes++;

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // leaves caller at the negedge of the first cycle after the boundary edge
    task automatic pulse_boundary();
        @(negedge clk) boundary_i = 1'b1;
        @(negedge clk) boundary_i = 1'b0;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic nmi_edge();
        @(negedge clk) nmi_i = 1'b1;
        settle(4);
    endtask

    // start: at k=0 negedge after a maskable take; walks the whole sequence
    task automatic run_ack(logic [7:0] ty, bit stall, bit poke_boundary);
        for (int k = 0; k < 10; k++) begin
            ack_data_i = (k == 6) ? ty : ~ty;
            if (k == 0) begin
                chk("R8 clr pulse", ien_clr_o, 1);
                chk("R8 saved flag", ien_save_o, ien_i);
                ien_i = 1'b0;
            end else chk("R8 clr single", ien_clr_o, 0);
            chk("R6 inta", inta_o, (k == 1 || k == 2 || k == 5 || k == 6));
            chk("R7 lock", lock_o, (k >= 1 && k <= 4));
            chk("R7 hold", hold_blk_o, (k <= 7));
            chk("R6 take", take_o, (k == 8));
            if (k == 8) chk("R9 vector", vec_o, {ty, 2'b00});
            if (poke_boundary) boundary_i = (k == 3);
            if (stall && k == 1) begin
                bus_tick_i = 1'b0;
                repeat (3) begin
                    @(negedge clk);
                    chk("R6 stall inta", inta_o, 1);
                    chk("R7 stall lock", lock_o, 1);
                end
                bus_tick_i = 1'b1;
            end
            @(negedge clk);
        end
        boundary_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 take", take_o, 0);
        chk("R1 inta", inta_o, 0);
        chk("R1 lock", lock_o, 0);
        chk("R1 hold", hold_blk_o, 0);
        chk("R1 clr", ien_clr_o, 0);
        pulse_boundary();
        chk("R1 no pending", take_o | hold_blk_o, 0);
    endtask

    task automatic t_nmi_basic(logic en);
        ien_i = en;
        nmi_edge();
        pulse_boundary();
        chk("R2 take", take_o, 1);
        chk("R2 vec", vec_o, 10'h008);
        chk("R8 clr", ien_clr_o, 1);
        chk("R8 save", ien_save_o, en);
        @(negedge clk);
        chk("R2 single", take_o, 0);
        chk("R8 clr single", ien_clr_o, 0);
        nmi_i = 1'b0;
        settle(3);
    endtask

    task automatic t_nmi_rearm();
        ien_i = 1'b0;
        nmi_edge();
        pulse_boundary();
        chk("R3 first", take_o, 1);
        // level still high, no new edge
        settle(2);
        pulse_boundary();
        chk("R3 level no retake", take_o, 0);
        nmi_i = 1'b0;
        settle(3);
        // edge right after service start
        pulse_boundary();
        chk("R3 idle", take_o, 0);
        @(negedge clk) nmi_i = 1'b1;
        pulse_boundary(); // boundary too early for the sync path
        chk("R3 not yet", take_o, 0);
        settle(3);
        pulse_boundary();
        chk("R3 rearm take", take_o, 1);
        chk("R3 rearm vec", vec_o, 10'h008);
        nmi_i = 1'b0;
        settle(3);
    endtask

    task automatic t_priority();
        ien_i = 1'b1;
        intr_i = 1'b1;
        nmi_edge();
        pulse_boundary();
        chk("R4 nmi first", take_o, 1);
        chk("R4 nmi vec", vec_o, 10'h008);
        chk("R4 no ack", hold_blk_o, 0);
        nmi_i = 1'b0;
        ien_i = 1'b1;
        pulse_boundary();
        chk("R4 intr after", hold_blk_o, 1);
        run_ack(8'h5A, 1'b0, 1'b0);
        intr_i = 1'b0;
        settle(2);
    endtask

    task automatic t_intr_gate();
        ien_i = 1'b0;
        intr_i = 1'b1;
        settle(2);
        pulse_boundary();
        chk("R5 masked", hold_blk_o, 0);
        settle(3);
        chk("R5 masked idle", takes, 2 + 2 + 1 + 1);
        intr_i = 1'b0;
        ien_i = 1'b1;
        settle(2);
        // rises with the boundary: not sampled in time
        @(negedge clk) begin intr_i = 1'b1; boundary_i = 1'b1; end
        @(negedge clk) boundary_i = 1'b0;
        chk("R5 late", hold_blk_o, 0);
        intr_i = 1'b0;
        settle(3);
    endtask

    task automatic t_intr_ack(logic [7:0] ty, bit stall, bit poke);
        ien_i = 1'b1;
        intr_i = 1'b1;
        settle(1);
        pulse_boundary();
        chk("R5 taken", hold_blk_o, 1);
        run_ack(ty, stall, poke);
        intr_i = 1'b0;
        chk("R10 no extra", hold_blk_o | take_o, 0);
        settle(2);
    endtask

    task automatic t_persist();
        intr_i = 1'b1;
        for (int n = 0; n < 2; n++) begin
            ien_i = 1'b1;
            settle(1);
            pulse_boundary();
            chk("R11 again", hold_blk_o, 1);
            run_ack(8'h21 + 8'(n), 1'b0, 1'b0);
        end
        pulse_boundary();
        chk("R11 gated by flag", hold_blk_o, 0);
        intr_i = 1'b0;
        settle(2);
    endtask

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(1);
        t_reset();
        t_nmi_basic(1'b1);
        t_nmi_basic(1'b0);
        t_nmi_rearm();
        t_priority();
        t_intr_gate();
        t_intr_ack(8'hFF, 1'b0, 1'b0);
        t_intr_ack(8'h00, 1'b1, 1'b0);
        t_intr_ack(8'h3C, 1'b0, 1'b1);
        t_persist();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule